// File: doc/BRIEF.md
# Microstepping Stepper Motor Indexer

This block turns step pulses into the two coil current setpoints of a bipolar stepper motor. It keeps a position register that stands for the electrical angle of the rotor field. On each rising edge of the step input it moves that position by one step of the selected resolution. The direction input sets whether it moves forward or backward. From the position it forms a signed setpoint for each coil. Coil A follows the sine of the angle and coil B follows the cosine.

A 4-bit mode input selects one of eleven resolutions. Nine of them follow the circular sine profile: full step at 71% current, then 1/2 through 1/256 step. The other two are square-drive profiles: full step at 100% current, and a non-circular half step. The mode may change between steps. The next step then lands on the nearest grid point of the new resolution in the direction of travel. A synchronous indexer-clear input returns the position to the 45-degree home state without a reset of the rest of the chip.

The position is a 10-bit index, so one electrical cycle spans 1024 positions and index 128 is 45 degrees. Each setpoint is a 9-bit two's-complement value, where +255 is +100% of full scale. Positive means current from the coil's first output to its second output.

Top module: `stepper_indexer`

## Requirements
- R1: After reset the position is 128 (45 degrees) and both coil outputs are +180 (71%).
- R2: A high idx_clr_i at a clock edge returns the position to 128 and both outputs to +180 in every mode, and it takes precedence over a step edge in the same cycle.
- R3: Only a rising edge of step_i moves the position. Holding step_i high, or low, leaves both outputs unchanged.
- R4: When dir_i is 1 a step moves the position forward (increasing angle). When dir_i is 0 it moves backward by the same stride.
- R5: In the circular modes, coil A equals round(255·sin θ) and coil B equals round(255·cos θ), each within ±1, where θ = 2π·position/1024.
- R6: The stride in positions per step is set by mode_i as follows: 0000, 0001 give 256; 0010, 0011 give 128; 0100 gives 64; 0101 gives 32; 0110 gives 16; 0111 gives 8; 1000 gives 4; 1001 gives 2; 1010 gives 1.
- R7: Mode 0000 (full step, 100%) uses the grid of odd multiples of 128. Its outputs are exactly ±255 on both coils, taking the sign of sine and cosine.
- R8: Mode 0010 (non-circular half step) visits multiples of 128. Each coil is 0 where its sine or cosine is zero and exactly ±255 elsewhere, giving eight states that start at (0, +255) for position 0.
- R9: If the position is off the grid of the current mode, a forward step moves to the next grid point above it and a backward step moves to the next grid point below it. The 71% and 100% full-step grids are offset by 128 and use a stride of 256; the other grids are aligned to 0.
- R10: Mode codes 1011 through 1111 behave as 1/256 step (stride 1, circular).
- R11: Mode 0001 (full step, 71%) visits odd multiples of 128, with both coils at ±180.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Step pulse, rising edge active |
| dir_i | input | 1 | 1 = forward, 0 = reverse |
| mode_i | input | 4 | Step resolution code |
| idx_clr_i | input | 1 | Synchronous return to home position |
| coil_a_o | output | 9 | Signed coil A setpoint (sine) |
| coil_b_o | output | 9 | Signed coil B setpoint (cosine) |

## Verification
The bench builds the block with its default widths: a 10-bit position and a 9-bit amplitude. With these widths the 1/256 mode steps through single positions and the full 257-entry quarter table lies on the stepping path. Forward runs in the coarse modes cross the wrap from 1023 to 0, and backward runs cross the wrap from 0 to 1023. The bench moves between fine and coarse modes while the position is off the grid, so the round-up and round-down paths of the realignment both run. It also applies a clear in the same cycle as a step edge, while in the square full-step mode.

// File: rtl/stepper_pkg.sv
package stepper_pkg;

  // log2 of the position stride for a given resolution code; qw is the
  // number of position bits per quarter cycle.
  function automatic int unsigned stride_shift(input logic [3:0] m,
                                               input int unsigned qw);
    int unsigned k;
    if (m == 4'd0 || m == 4'd1) begin
      k = 0;
    end else if (m == 4'd2) begin
      k = 1;
    end else if (m > 4'd10) begin
      k = 8;
    end else begin
      k = 32'(m) - 2;
    end
    return (k >= qw) ? 0 : qw - k;
  endfunction

  // Full-step grids sit on odd multiples of 45 degrees.
  function automatic logic grid_offset45(input logic [3:0] m);
    return (m == 4'd0) || (m == 4'd1);
  endfunction

  // Square-drive profiles: full step 100% and non-circular half step.
  function automatic logic square_drive(input logic [3:0] m);
    return (m == 4'd0) || (m == 4'd2);
  endfunction

  // Rational sine approximation over the first quarter:
  // sin(x) ~ 16 p / (5 N^2 - 4 p), p = u (N - u), N = half-cycle count.
  function automatic int quarter_sine(input int u, input int half_n,
                                      input int fs);
    longint p;
    longint num;
    longint den;
    p   = longint'(u) * longint'(half_n - u);
    num = 64'd16 * longint'(fs) * p;
    den = 64'd5 * longint'(half_n) * longint'(half_n) - 64'd4 * p;
    return int'((num + den / 2) / den);
  endfunction

endpackage

// File: rtl/quarter_sine_rom.sv
module quarter_sine_rom
  import stepper_pkg::*;
#(
  parameter int QW    = 8,
  parameter int MAG_W = 8
) (
  input  logic [QW:0]      idx_i,
  output logic [MAG_W-1:0] mag_o
);
  localparam int ENTRIES = (1 << QW) + 1;
  localparam int FS      = (1 << MAG_W) - 1;
  localparam int HALF_N  = 1 << (QW + 1);

  logic [MAG_W-1:0] tbl [ENTRIES];

  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_ent
    localparam int V = quarter_sine(gi, HALF_N, FS);
    assign tbl[gi] = MAG_W'(V);
  end

  assign mag_o = (32'(idx_i) < ENTRIES) ? tbl[idx_i] : '0;
endmodule

// File: rtl/coil_wave.sv
module coil_wave
  import stepper_pkg::*;
#(
  parameter int POS_W = 10,
  parameter int AMP_W = 9,
  parameter int PHASE = 0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [POS_W-1:0]        pos_i,
  input  logic                    sq_i,
  output logic signed [AMP_W-1:0] amp_o
);
  localparam int QW = POS_W - 2;
  localparam int MW = AMP_W - 1;
  localparam logic [MW-1:0] FS = {MW{1'b1}};
  localparam logic [QW:0]   QTR = (QW+1)'(1 << QW);

  logic [POS_W-1:0] ph;
  logic [QW-1:0]    q;
  logic [QW:0]      idx;
  logic             neg;
  logic [MW-1:0]    rom_mag;
  logic [MW-1:0]    mag;

  assign ph  = pos_i + POS_W'(PHASE);
  assign q   = ph[QW-1:0];
  assign idx = ph[QW] ? (QTR - {1'b0, q}) : {1'b0, q};
  assign neg = ph[QW+1];

  quarter_sine_rom #(.QW(QW), .MAG_W(MW)) rom_i (
    .idx_i (idx),
    .mag_o (rom_mag)
  );

  always_comb begin
    if (sq_i) mag = (idx == '0) ? '0 : FS;
    else      mag = rom_mag;
    amp_o = neg ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  end

  // R7/R8: square drive yields only zero or full scale
  a_r8_square_levels: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sq_i |-> (amp_o == 0 || amp_o == $signed({1'b0, FS}) ||
              amp_o == -$signed({1'b0, FS})));
endmodule

// File: rtl/indexer_pos_ctrl.sv
module indexer_pos_ctrl
  import stepper_pkg::*;
#(
  parameter int POS_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             dir_i,
  input  logic [3:0]       mode_i,
  input  logic             idx_clr_i,
  output logic [POS_W-1:0] pos_o,
  output logic             sq_o
);
  localparam int QW = POS_W - 2;
  localparam logic [POS_W-1:0] HOME = POS_W'(1) << (POS_W - 3);

  logic             step_q;
  logic             step_rise;
  logic [POS_W-1:0] pos_q, pos_nx;
  logic             sq_q;
  int unsigned      sh;
  logic [POS_W-1:0] stride, mask, off, rel, base;
  logic             aligned;

  assign step_rise = step_i & ~step_q;

  always_comb begin
    sh      = stride_shift(mode_i, QW);
    stride  = POS_W'(1) << sh;
    mask    = stride - POS_W'(1);
    off     = grid_offset45(mode_i) ? HOME : '0;
    rel     = pos_q - off;
    base    = rel & ~mask;
    aligned = (rel & mask) == '0;
    if (dir_i)        pos_nx = off + base + stride;
    else if (aligned) pos_nx = off + base - stride;
    else              pos_nx = off + base;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= 1'b0;
      pos_q  <= HOME;
      sq_q   <= 1'b0;
    end else begin
      step_q <= step_i;
      if (idx_clr_i) begin
        pos_q <= HOME;
        sq_q  <= 1'b0;
      end else if (step_rise) begin
        pos_q <= pos_nx;
        sq_q  <= square_drive(mode_i);
      end
    end
  end

  assign pos_o = pos_q;
  assign sq_o  = sq_q;

  a_r2_clear_home: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_clr_i |=> (pos_q == HOME && !sq_q));

  a_r3_hold_without_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_rise && !idx_clr_i) |=> ($stable(pos_q) && $stable(sq_q)));

  a_r4_forward_stride: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_rise && !idx_clr_i && dir_i && aligned) |=>
      (pos_q == $past(pos_q) + $past(stride)));

  a_r4_reverse_stride: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_rise && !idx_clr_i && !dir_i && aligned) |=>
      (pos_q == $past(pos_q) - $past(stride)));

  a_r9_lands_on_grid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_rise && !idx_clr_i) |=> (((pos_q - $past(off)) & $past(mask)) == '0));
endmodule

// File: rtl/stepper_indexer.sv
module stepper_indexer
  import stepper_pkg::*;
#(
  parameter int POS_W = 10,
  parameter int AMP_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    step_i,
  input  logic                    dir_i,
  input  logic [3:0]              mode_i,
  input  logic                    idx_clr_i,
  output logic signed [AMP_W-1:0] coil_a_o,
  output logic signed [AMP_W-1:0] coil_b_o
);
  localparam int QW = POS_W - 2;
  localparam int FS = (1 << (AMP_W - 1)) - 1;

  logic [POS_W-1:0]        pos_w;
  logic                    sq_w;
  logic signed [AMP_W-1:0] coil_w [2];

  indexer_pos_ctrl #(.POS_W(POS_W)) ctrl_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step_i),
    .dir_i     (dir_i),
    .mode_i    (mode_i),
    .idx_clr_i (idx_clr_i),
    .pos_o     (pos_w),
    .sq_o      (sq_w)
  );

  // coil 0 = sine (A), coil 1 = cosine (B), a quarter cycle ahead
  for (genvar gc = 0; gc < 2; gc++) begin : g_coil
    coil_wave #(.POS_W(POS_W), .AMP_W(AMP_W),
                .PHASE(gc * (1 << QW))) wave_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pos_i  (pos_w),
      .sq_i   (sq_w),
      .amp_o  (coil_w[gc])
    );
  end

  assign coil_a_o = coil_w[0];
  assign coil_b_o = coil_w[1];

  a_r5_amp_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coil_a_o <= FS && coil_a_o >= -FS && coil_b_o <= FS && coil_b_o >= -FS));

  a_r3_outputs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(pos_w) && $stable(sq_w) |-> $stable(coil_a_o) && $stable(coil_b_o));
endmodule

// File: tb/stepper_indexer_tb_top.sv
`timescale 1ns/100ps
module stepper_indexer_tb_top;
  localparam int NPOS = 1024;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step = 1'b0;
  logic dir = 1'b1;
  logic [3:0] mode = 4'd5;
  logic clr = 1'b0;
  logic signed [8:0] coil_a, coil_b;

  always #2.5 clk = ~clk;

  stepper_indexer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .dir_i(dir),
    .mode_i(mode), .idx_clr_i(clr), .coil_a_o(coil_a), .coil_b_o(coil_b)
  );

  typedef struct { int a; int b; int tol; string tag; } exp_t;
  exp_t sb_q[$];
  event mon_ev;
  int errors = 0;
  int checks = 0;
  int m_pos = 128;
  bit m_sq = 0;
  bit done = 0;

  function automatic int stride_of(input logic [3:0] m);
    case (m)
      4'd0, 4'd1: return 256;
      4'd2, 4'd3: return 128;
      4'd4: return 64;
      4'd5: return 32;
      4'd6: return 16;
      4'd7: return 8;
      4'd8: return 4;
      4'd9: return 2;
      default: return 1;
    endcase
  endfunction

  function automatic int rnd(input real r);
    return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
  endfunction

  function automatic bit on_grid(input int p, input logic [3:0] m);
    int off = (m <= 4'd1) ? 128 : 0;
    return ((p - off + NPOS) % stride_of(m)) == 0;
  endfunction

  task automatic push_expect(input string tag);
    exp_t e;
    if (m_sq) begin
      e.a = (m_pos % 512 == 0) ? 0 : ((m_pos < 512) ? 255 : -255);
      e.b = ((m_pos + 256) % 512 == 0) ? 0 :
            ((m_pos < 256 || m_pos > 768) ? 255 : -255);
      e.tol = 0;
    end else begin
      e.a = rnd(255.0 * $sin(2.0 * PI * m_pos / NPOS));
      e.b = rnd(255.0 * $cos(2.0 * PI * m_pos / NPOS));
      e.tol = 1;
    end
    e.tag = tag;
    sb_q.push_back(e);
    ->mon_ev;
  endtask

  // monitor: pops the oldest expectation and compares the ports
  initial begin
    forever begin
      exp_t e;
      @(mon_ev);
      while (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        checks += 2;
        if (int'(coil_a) > e.a + e.tol || int'(coil_a) < e.a - e.tol) begin
          errors++;
          $display("FAIL %s coil A: actual %0d expected %0d (pos %0d)", e.tag, coil_a, e.a, m_pos);
        end
        if (int'(coil_b) > e.b + e.tol || int'(coil_b) < e.b - e.tol) begin
          errors++;
          $display("FAIL %s coil B: actual %0d expected %0d (pos %0d)", e.tag, coil_b, e.b, m_pos);
        end
      end
    end
  end

  task automatic set_mode(input logic [3:0] m);
    @(negedge clk);
    mode = m;
  endtask

  task automatic do_step(input bit d, input string tag);
    @(negedge clk);
    dir = d;
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
    do begin
      m_pos = d ? (m_pos + 1) % NPOS : (m_pos + NPOS - 1) % NPOS;
    end while (!on_grid(m_pos, mode));
    m_sq = (mode == 4'd0) || (mode == 4'd2);
    push_expect(tag);
    @(negedge clk);
  endtask

  task automatic steps(input int n, input bit d, input string tag);
    for (int i = 0; i < n; i++) do_step(d, tag);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    push_expect("R1 home after reset");

    set_mode(4'd5);
    steps(4, 1'b1, "R6 R5 R4 eighth step forward");
    steps(2, 1'b0, "R4 eighth step reverse");

    // R3: hold step high for several cycles, then low: no further motion
    do_step(1'b1, "R3 single edge");
    @(negedge clk); step = 1'b1;
    @(negedge clk);
    do begin m_pos = (m_pos + 1) % NPOS; end while (!on_grid(m_pos, mode));
    push_expect("R3 edge while held");
    repeat (4) @(negedge clk);
    push_expect("R3 level held high no motion");
    step = 1'b0;
    repeat (3) @(negedge clk);
    push_expect("R3 level low no motion");

    set_mode(4'd10);
    steps(3, 1'b1, "R6 1/256 forward");
    set_mode(4'd15);
    steps(2, 1'b1, "R10 code 1111 as 1/256");
    set_mode(4'd12);
    steps(1, 1'b0, "R10 code 1100 as 1/256");

    // off grid now; coarse mode rounds up forward, down in reverse
    set_mode(4'd4);
    steps(1, 1'b1, "R9 round up to quarter grid");
    set_mode(4'd10);
    steps(3, 1'b1, "R6 fine step off grid");
    set_mode(4'd4);
    steps(1, 1'b0, "R9 round down to quarter grid");
    set_mode(4'd1);
    steps(1, 1'b1, "R9 full step grid offset 45");

    steps(5, 1'b1, "R11 full step 71 forward wrap");
    steps(2, 1'b0, "R11 full step 71 reverse");
    set_mode(4'd0);
    steps(4, 1'b1, "R7 full step 100");
    set_mode(4'd2);
    steps(9, 1'b1, "R8 non-circular half step");
    steps(3, 1'b0, "R8 non-circular reverse");
    set_mode(4'd3);
    steps(3, 1'b1, "R5 circular half step");

    // R2: clear together with a step edge, from square drive mode
    set_mode(4'd0);
    steps(1, 1'b1, "R7 before clear");
    @(negedge clk);
    clr = 1'b1; step = 1'b1;
    @(negedge clk);
    clr = 1'b0; step = 1'b0;
    m_pos = 128; m_sq = 0;
    push_expect("R2 clear wins over step");
    @(negedge clk);
    steps(1, 1'b1, "R2 stepping resumes after clear");

    for (int m = 6; m <= 9; m++) begin
      set_mode(4'(m));
      steps(2, 1'b1, "R6 fine modes forward");
      steps(1, 1'b0, "R6 fine modes reverse");
    end

    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule